// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block owns a small local store of transmit descriptors and walks it as a ring on behalf of a transmit path. Each descriptor holds two 32-bit words: a status word and a buffer address. Software fills descriptors through a write port and hands each one to the hardware by setting its ownership bit. It then writes the poll value to start a scan.

The walker reads the descriptor at its current ring index. If the hardware owns that descriptor, the walker presents a send request carrying the buffer address, the frame length and the segment flags, and holds it until the transmit side answers with a done strobe. Short frames are raised to a minimum length. After the done strobe the walker clears the ownership bit in place, raises a one-cycle completion pulse and moves on. It goes to slot zero after a descriptor marked end-of-ring, or after the last slot of the store.

Scanning stops at the first descriptor that software still owns, and the walker keeps its index there. A poll that arrives during a scan is remembered, so the ring is scanned again once the walker falls idle.

Top module: `txring_walker`

## Requirements
- R1: After reset the walker is idle at ring index 0, with no send request and no completion pulse, and every descriptor word reads as zero.
- R2: A poll write starts a scan only when its data byte equals 0x40; a poll write with any other value leaves the walker idle.
- R3: For a descriptor whose status bit 31 (ownership) is set, the walker drives send_req with send_addr taken from the address word, send_first from status bit 29 and send_last from status bit 28. It holds these steady until send_done is sampled high.
- R4: The length sent is status bits 15:0, except that a value below MIN_LEN (default 60) is sent as MIN_LEN.
- R5: In the cycle after send_done is sampled during a request, tx_done is high for exactly one cycle. In that same cycle the descriptor reads back with bit 31 cleared and all its other bits unchanged.
- R6: After a completion the index moves to the next slot. It goes to 0 instead when the completed descriptor had status bit 30 (end-of-ring) set, or when it sat in slot DEPTH-1.
- R7: When the descriptor at the current index has bit 31 clear, the walker goes idle and keeps that index until the next poll.
- R8: A valid poll that arrives while the walker is busy, including the cycle in which it finds an unowned descriptor, is remembered and causes one new scan after the walker goes idle.
- R9: When a software write to a status word and a hardware ownership clear of the same descriptor fall on the same clock edge, the software value is stored intact.
- R10: A send_done strobe outside a request has no effect: no completion pulse and no index change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr_en | input | 1 | Software descriptor write strobe |
| desc_wr_idx | input | IDX_W | Descriptor slot to write |
| desc_wr_sel | input | 1 | Word select: 0 status, 1 buffer address |
| desc_wr_data | input | 32 | Word written |
| desc_rd_idx | input | IDX_W | Descriptor slot to read back |
| desc_rd_sel | input | 1 | Word select for read-back |
| desc_rd_data | output | 32 | Read-back word (combinational) |
| poll_wr_en | input | 1 | Poll register write strobe |
| poll_wr_data | input | 8 | Poll register data; 0x40 starts a scan |
| send_req | output | 1 | Send request to the transmit side |
| send_addr | output | ADDR_W | Buffer address of the frame |
| send_len | output | 16 | Frame length after the minimum-length floor |
| send_first | output | 1 | First-segment flag |
| send_last | output | 1 | Last-segment flag |
| send_done | input | 1 | Transmit side finished the request |
| tx_done | output | 1 | One-cycle completion pulse |
| ring_idx | output | IDX_W | Current ring index |
| busy | output | 1 | Walker is scanning or sending |

## Verification
Two kinds of event can meet in one clock edge. The first is a poll write and the walker's decision to stop at an unowned descriptor. The bench places a poll exactly on the cycle in which the walker inspects a software-owned slot, and on that same edge it makes the slot owned. The reference model then expects the walker to drop to idle and rescan by itself two cycles later to send that slot. The second is a software status write and the hardware ownership clear on one descriptor. The bench raises send_done and a status write to the slot being sent on the same edge, and it expects the software word, with its ownership bit still set, to read back afterwards.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
   localparam int WORD_W  = 32;
   localparam int LEN_W   = 16;
   localparam int OWN_BIT = 31;
   localparam int EOR_BIT = 30;
   localparam int FS_BIT  = 29;
   localparam int LS_BIT  = 28;
   localparam logic [7:0] POLL_VALUE = 8'h40;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_SEND  = 2'd2
   } walk_st_e;
endpackage

// File: rtl/tdw_desc_mem.sv
module tdw_desc_mem
   import tdw_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [IDX_W-1:0]  sw_idx,
   input  logic              sw_sel,
   input  logic [WORD_W-1:0] sw_wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_sel,
   output logic [WORD_W-1:0] rd_data,
   input  logic [IDX_W-1:0]  walk_idx,
   input  logic              hw_clr,
   output logic              walk_own,
   output logic              walk_eor,
   output logic              walk_fs,
   output logic              walk_ls,
   output logic [LEN_W-1:0]  walk_len,
   output logic [ADDR_W-1:0] walk_addr
);
   logic [WORD_W-1:0] stat_q [DEPTH];
   logic [WORD_W-1:0] addr_q [DEPTH];

   // Hardware clear is issued first so a same-edge software write overrides it.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            stat_q[i] <= '0;
            addr_q[i] <= '0;
         end
      end else begin
         if (hw_clr) stat_q[walk_idx][OWN_BIT] <= 1'b0;
         if (sw_we) begin
            if (sw_sel) addr_q[sw_idx] <= sw_wdata;
            else        stat_q[sw_idx] <= sw_wdata;
         end
      end
   end

   assign rd_data   = rd_sel ? addr_q[rd_idx] : stat_q[rd_idx];
   assign walk_own  = stat_q[walk_idx][OWN_BIT];
   assign walk_eor  = stat_q[walk_idx][EOR_BIT];
   assign walk_fs   = stat_q[walk_idx][FS_BIT];
   assign walk_ls   = stat_q[walk_idx][LS_BIT];
   assign walk_len  = stat_q[walk_idx][LEN_W-1:0];
   assign walk_addr = addr_q[walk_idx][ADDR_W-1:0];

   // R5: a completed slot reads back unowned unless software rewrote it
   p_own_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr && !(sw_we && !sw_sel && sw_idx == walk_idx)
      |=> stat_q[$past(walk_idx)][OWN_BIT] == 1'b0);

   // R9: a software status write always lands intact
   p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we && !sw_sel |=> stat_q[$past(sw_idx)] == $past(sw_wdata));
endmodule

// File: rtl/tdw_len_floor.sv
module tdw_len_floor
   import tdw_pkg::*;
#(
   parameter int MIN_LEN   = 60,
   parameter bit PAD_SHORT = 1'b1
) (
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-1:0] len_o
);
   localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_LEN);

   generate
      if (PAD_SHORT) begin : g_pad
         assign len_o = (len_i < FLOOR) ? FLOOR : len_i;
      end else begin : g_raw
         assign len_o = len_i;
      end
   endgenerate
endmodule

// File: rtl/tdw_ring_ctrl.sv
module tdw_ring_ctrl
   import tdw_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll_hit,
   input  logic             desc_own,
   input  logic             desc_eor,
   input  logic             send_done,
   output logic             load,
   output logic             hw_clr,
   output logic             send_req,
   output logic             done_pulse,
   output logic             busy,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   walk_st_e         st_q;
   logic [IDX_W-1:0] idx_q;
   logic             pend_q;
   logic             eor_q;
   logic             done_q;
   logic [IDX_W-1:0] idx_nxt;

   assign idx_nxt = (eor_q || idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         pend_q <= 1'b0;
         eor_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (poll_hit || pend_q) begin
                  st_q   <= ST_FETCH;
                  pend_q <= 1'b0;
               end
            end
            ST_FETCH: begin
               if (poll_hit) pend_q <= 1'b1;
               if (desc_own) begin
                  st_q  <= ST_SEND;
                  eor_q <= desc_eor;
               end else begin
                  st_q <= ST_IDLE;
               end
            end
            ST_SEND: begin
               if (poll_hit) pend_q <= 1'b1;
               if (send_done) begin
                  done_q <= 1'b1;
                  idx_q  <= idx_nxt;
                  st_q   <= ST_FETCH;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign load       = (st_q == ST_FETCH) && desc_own;
   assign hw_clr     = (st_q == ST_SEND) && send_done;
   assign send_req   = (st_q == ST_SEND);
   assign done_pulse = done_q;
   assign busy       = (st_q != ST_IDLE);
   assign idx        = idx_q;

   // R2: an accepted poll in idle begins a fetch
   p_poll_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_IDLE && poll_hit |=> st_q == ST_FETCH);

   // R5: the completion pulse never lasts two cycles
   p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R6: an end-of-ring completion returns the index to slot zero
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr && eor_q |=> idx_q == '0);

   // R7: an unowned slot ends the scan without moving the index
   p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_FETCH && !desc_own |=> st_q == ST_IDLE && $stable(idx_q));

   // R8: a poll heard while busy is kept for a later scan
   p_poll_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != ST_IDLE && poll_hit |=> pend_q || st_q == ST_IDLE);

   // R10: without an open request no completion is reported
   p_no_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != ST_SEND |=> !done_q && $stable(idx_q));
endmodule

// File: rtl/txring_walker.sv
module txring_walker
   import tdw_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int ADDR_W    = 32,
   parameter int MIN_LEN   = 60,
   parameter bit PAD_SHORT = 1'b1,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_wr_en,
   input  logic [IDX_W-1:0]  desc_wr_idx,
   input  logic              desc_wr_sel,
   input  logic [31:0]       desc_wr_data,
   input  logic [IDX_W-1:0]  desc_rd_idx,
   input  logic              desc_rd_sel,
   output logic [31:0]       desc_rd_data,
   input  logic              poll_wr_en,
   input  logic [7:0]        poll_wr_data,
   output logic              send_req,
   output logic [ADDR_W-1:0] send_addr,
   output logic [15:0]       send_len,
   output logic              send_first,
   output logic              send_last,
   input  logic              send_done,
   output logic              tx_done,
   output logic [IDX_W-1:0]  ring_idx,
   output logic              busy
);
   initial begin
      if (DEPTH < 2)                  $fatal(1, "ring needs at least two slots");
      if (ADDR_W < 1 || ADDR_W > 32)  $fatal(1, "address width out of range");
      if (MIN_LEN < 0 || MIN_LEN > 65535) $fatal(1, "minimum length out of range");
   end

   logic             poll_hit;
   logic             w_own, w_eor, w_fs, w_ls;
   logic [LEN_W-1:0] w_len, w_len_fl;
   logic [ADDR_W-1:0] w_addr;
   logic             load, hw_clr;

   assign poll_hit = poll_wr_en && (poll_wr_data == POLL_VALUE);

   tdw_desc_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (desc_wr_en),
      .sw_idx   (desc_wr_idx),
      .sw_sel   (desc_wr_sel),
      .sw_wdata (desc_wr_data),
      .rd_idx   (desc_rd_idx),
      .rd_sel   (desc_rd_sel),
      .rd_data  (desc_rd_data),
      .walk_idx (ring_idx),
      .hw_clr   (hw_clr),
      .walk_own (w_own),
      .walk_eor (w_eor),
      .walk_fs  (w_fs),
      .walk_ls  (w_ls),
      .walk_len (w_len),
      .walk_addr(w_addr)
   );

   tdw_len_floor #(.MIN_LEN(MIN_LEN), .PAD_SHORT(PAD_SHORT)) u_floor (
      .len_i (w_len),
      .len_o (w_len_fl)
   );

   tdw_ring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .poll_hit  (poll_hit),
      .desc_own  (w_own),
      .desc_eor  (w_eor),
      .send_done (send_done),
      .load      (load),
      .hw_clr    (hw_clr),
      .send_req  (send_req),
      .done_pulse(tx_done),
      .busy      (busy),
      .idx       (ring_idx)
   );

   // Request fields are captured once so later software writes cannot disturb them.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         send_addr  <= '0;
         send_len   <= '0;
         send_first <= 1'b0;
         send_last  <= 1'b0;
      end else if (load) begin
         send_addr  <= w_addr;
         send_len   <= w_len_fl;
         send_first <= w_fs;
         send_last  <= w_ls;
      end
   end

   // R3: an open request holds its fields until answered
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      send_req && !send_done |=> send_req && $stable(send_addr) && $stable(send_len)
                                 && $stable(send_first) && $stable(send_last));

   // R4: no request goes out below the floor when padding is on
   p_len_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      send_req && PAD_SHORT |-> send_len >= LEN_W'(MIN_LEN));

   // R5: each completion pulse follows an answered request
   p_done_after_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> $past(send_req && send_done));
endmodule

// File: tb/tb_txring_walker.sv
module tb_txring_walker;
   localparam int DEPTH   = 8;
   localparam int IDX_W   = 3;
   localparam int MIN_LEN = 60;

   logic             clk, rst_n;
   logic             desc_wr_en, desc_wr_sel;
   logic [IDX_W-1:0] desc_wr_idx, desc_rd_idx;
   logic [31:0]      desc_wr_data, desc_rd_data;
   logic             desc_rd_sel;
   logic             poll_wr_en;
   logic [7:0]       poll_wr_data;
   logic             send_req, send_first, send_last, send_done;
   logic [31:0]      send_addr;
   logic [15:0]      send_len;
   logic             tx_done, busy;
   logic [IDX_W-1:0] ring_idx;

   txring_walker #(.DEPTH(DEPTH), .ADDR_W(32), .MIN_LEN(MIN_LEN), .PAD_SHORT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx), .desc_wr_sel(desc_wr_sel),
      .desc_wr_data(desc_wr_data), .desc_rd_idx(desc_rd_idx), .desc_rd_sel(desc_rd_sel),
      .desc_rd_data(desc_rd_data), .poll_wr_en(poll_wr_en), .poll_wr_data(poll_wr_data),
      .send_req(send_req), .send_addr(send_addr), .send_len(send_len),
      .send_first(send_first), .send_last(send_last), .send_done(send_done),
      .tx_done(tx_done), .ring_idx(ring_idx), .busy(busy)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit fin = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wrap_up();
      fin = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_stat [DEPTH];
   logic [31:0] m_addr [DEPTH];
   int          m_mode, m_idx, m_len;
   bit          m_pend, m_eor, m_fs, m_ls, m_done, m_hit;
   logic [31:0] m_a;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_stat[i]) begin m_stat[i] = '0; m_addr[i] = '0; end
         m_mode = 0; m_idx = 0; m_pend = 0; m_eor = 0; m_done = 0;
         m_a = '0; m_len = 0; m_fs = 0; m_ls = 0;
      end else begin
         m_hit  = poll_wr_en && poll_wr_data == 8'h40;
         m_done = 0;
         case (m_mode)
            0: if (m_hit || m_pend) begin m_mode = 1; m_pend = 0; end
            1: begin
               if (m_hit) m_pend = 1;
               if (m_stat[m_idx][31]) begin
                  m_mode = 2;
                  m_a    = m_addr[m_idx];
                  m_len  = int'(m_stat[m_idx][15:0]);
                  if (m_len < MIN_LEN) m_len = MIN_LEN;
                  m_fs   = m_stat[m_idx][29];
                  m_ls   = m_stat[m_idx][28];
                  m_eor  = m_stat[m_idx][30];
               end else m_mode = 0;
            end
            default: begin
               if (m_hit) m_pend = 1;
               if (send_done) begin
                  m_stat[m_idx][31] = 1'b0;
                  m_done = 1;
                  m_idx  = (m_eor || m_idx == DEPTH - 1) ? 0 : m_idx + 1;
                  m_mode = 1;
               end
            end
         endcase
         if (desc_wr_en) begin
            if (desc_wr_sel) m_addr[desc_wr_idx] = desc_wr_data;
            else             m_stat[desc_wr_idx] = desc_wr_data;
         end
      end
   end

   // ---------------- per-cycle comparison and responder ----------------
   bit               auto_en = 0, auto_done = 0, man_done = 0, hold_rd = 0;
   int               lat = 2, rcnt = 0, rot = 0;
   logic [IDX_W-1:0] hold_idx = '0;
   bit               hold_sel = 0;
   assign send_done = auto_done | man_done;

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         chk("R3 send_req", send_req, 32'(m_mode == 2));
         if (m_mode == 2) begin
            chk("R3 send_addr", send_addr, m_a);
            chk("R4 send_len", send_len, 32'(m_len));
            chk("R3 send_first", send_first, 32'(m_fs));
            chk("R3 send_last", send_last, 32'(m_ls));
         end
         chk("R5 tx_done", tx_done, 32'(m_done));
         chk("R6 ring_idx", ring_idx, 32'(m_idx));
         chk("R7 busy", busy, 32'(m_mode != 0));
         if (!hold_rd)
            chk("R5 readback", desc_rd_data,
                desc_rd_sel ? m_addr[desc_rd_idx] : m_stat[desc_rd_idx]);
      end
      rot++;
      desc_rd_idx = hold_rd ? hold_idx : IDX_W'(rot >> 1);
      desc_rd_sel = hold_rd ? hold_sel : rot[0];
      auto_done = 0;
      if (auto_en && send_req) begin
         rcnt++;
         if (rcnt >= lat) begin auto_done = 1; rcnt = 0; end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !fin) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         wrap_up();
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input int idx, input bit sel, input logic [31:0] d);
      @(negedge clk);
      desc_wr_en = 1; desc_wr_idx = IDX_W'(idx); desc_wr_sel = sel; desc_wr_data = d;
      @(negedge clk);
      desc_wr_en = 0;
   endtask

   task automatic poll(input logic [7:0] d);
      @(negedge clk);
      poll_wr_en = 1; poll_wr_data = d;
      @(negedge clk);
      poll_wr_en = 0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      for (int k = 0; k < 1000; k++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_req();
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (send_req) break;
      end
   endtask

   initial begin
      rst_n = 0; desc_wr_en = 0; desc_wr_idx = '0; desc_wr_sel = 0; desc_wr_data = '0;
      poll_wr_en = 0; poll_wr_data = '0; desc_rd_idx = '0; desc_rd_sel = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 ring_idx", ring_idx, 0);
      chk("R1 send_req", send_req, 0);
      chk("R1 tx_done", tx_done, 0);
      chk("R1 readback", desc_rd_data, 0);

      // R2: only the exact poll value starts a scan
      auto_en = 1; lat = 2;
      wr(0, 1, 32'h0000_1000);
      wr(0, 0, 32'hB000_0064);
      poll(8'hBF);
      repeat (3) @(negedge clk);
      chk("R2 ignored busy", busy, 0);
      chk("R2 ignored req", send_req, 0);
      poll(8'hC0);
      repeat (3) @(negedge clk);
      chk("R2 ignored C0", busy, 0);
      poll(8'h40);
      wait_idle();
      chk("R2 started", ring_idx, 1);

      // R4/R6: short, exact and long lengths, end-of-ring wrap
      wr(1, 1, 32'h0000_2000); wr(1, 0, 32'hA000_000A);
      wr(2, 1, 32'h0000_3000); wr(2, 0, 32'h8000_003C);
      wr(3, 1, 32'h0000_4000); wr(3, 0, 32'hF000_003D);
      poll(8'h40);
      wait_idle();
      chk("R6 eor wrap", ring_idx, 0);

      // R6/R8: full ring wraps after last slot; poll mid-scan is kept
      for (int i = 0; i < DEPTH; i++) begin
         wr(i, 1, 32'h0001_0000 + 32'(i * 16));
         wr(i, 0, 32'h9000_0000 | 32'(100 + i));
      end
      poll(8'h40);
      repeat (6) @(negedge clk);
      poll(8'h40);
      wait_idle();
      chk("R6 end wrap", ring_idx, 0);

      // R7: stop at a software-owned slot and hold the index
      wr(0, 0, 32'h9000_05DC);
      poll(8'h40);
      wait_idle();
      chk("R7 stop idx", ring_idx, 1);
      repeat (5) @(negedge clk);
      chk("R7 hold idx", ring_idx, 1);

      // R10: stray done while idle
      @(negedge clk); man_done = 1;
      @(negedge clk); man_done = 0;
      chk("R10 no pulse", tx_done, 0);
      repeat (2) @(negedge clk);
      chk("R10 idx kept", ring_idx, 1);

      // R9: software status write on the edge of the ownership clear
      auto_en = 0;
      wr(1, 1, 32'h0005_0000); wr(1, 0, 32'h9000_00C8);
      poll(8'h40);
      wait_req();
      man_done = 1; desc_wr_en = 1; desc_wr_idx = 1; desc_wr_sel = 0;
      desc_wr_data = 32'h9000_1234;
      @(negedge clk);
      man_done = 0; desc_wr_en = 0;
      wait_idle();
      hold_idx = 1; hold_sel = 0; hold_rd = 1;
      repeat (2) @(negedge clk);
      chk("R9 sw word kept", desc_rd_data, 32'h9000_1234);
      hold_rd = 0;

      // R8: poll on the cycle a software-owned slot is found
      wr(2, 0, 32'h9000_0046);
      poll(8'h40);
      wait_req();
      man_done = 1;
      @(negedge clk);
      man_done = 0; poll_wr_en = 1; poll_wr_data = 8'h40;
      desc_wr_en = 1; desc_wr_idx = 3; desc_wr_sel = 0; desc_wr_data = 32'hF000_0050;
      @(negedge clk);
      poll_wr_en = 0; desc_wr_en = 0;
      repeat (2) @(negedge clk);
      chk("R8 rescan req", send_req, 1);
      chk("R8 rescan len", send_len, 32'h50);
      man_done = 1;
      @(negedge clk);
      man_done = 0;
      wait_idle();
      chk("R6 eor after rescan", ring_idx, 0);

      repeat (4) @(negedge clk);
      wrap_up();
   end
endmodule